// File: doc/BRIEF.md
# Isolating two-wire bus buffer with stuck-bus recovery

The block sits between a controller-side two-wire serial bus (clock line and data line) and a target-side bus that carries every target device. Each line on each side is modelled as a sampled level input and a pull-low enable output. In the linked mode, a low seen on one side is copied to the same line on the other side one clock later. The block tells its own pull apart from a low driven from outside, so a low it is driving is never sent back to the side it came from.

When a target-side line stays low without a break for a configured time, the block cuts the link. It then releases both controller-side lines, raises `fault`, and drives a fixed burst of clock pulses on the target-side clock line only. A target that was stalled mid-byte can finish its bit and let go of the data line.

At the end of the burst the block samples the target side. If both lines read high, the link is restored. If either line is still low, the block stays cut off for one more stuck-time window, runs the burst again, and repeats this until the bus reads idle. All pins are plain level and control signals; the block has no streaming interface, so no back-pressure rules apply.

Top module: `i2c_iso_buffer`

## Requirements
- R1: After reset, all four pull enables are 0 and `fault` is 0.
- R2: In the linked mode, a low sampled on a controller-side line drives the pull enable of the same target-side line from the next cycle on. The enable drops one cycle after the line is released.
- R3: In the linked mode, a low sampled on a target-side line drives the pull enable of the same controller-side line from the next cycle on. The enable drops one cycle after the line is released.
- R4: The block never pulls a line low because of a low that its own pull on the opposite side caused. This guard covers the cycle in which it drives that pull and the one cycle after the pull is released.
- R5: Each target-side line has its own stuck timer, and the limit is LIMIT = CLK_KHZ × STUCK_MS cycles. `fault` rises on the edge that samples the LIMIT-th consecutive low of one line. A low that ends earlier restarts that line's count and has no effect.
- R6: While `fault` is 1, both controller-side pull enables and the target-side data pull enable stay 0. Controller-side activity has no effect on the target side.
- R7: A recovery burst lasts 2 × PULSES × HALF cycles, with HALF = CLK_KHZ / (2 × REC_KHZ) and a minimum of 1. It starts in the first cycle of `fault` with the target clock pull enable at 1. That enable is 1 for HALF cycles and then 0 for HALF cycles, and this repeats PULSES times.
- R8: If both target-side lines read high at the last cycle of a burst, `fault` falls on that edge and the linked mode resumes with all pull enables at 0.
- R9: If either target-side line reads low at the last cycle of a burst, the block stays isolated with no pull enable set for LIMIT cycles, then runs another burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_scl_i | input | 1 | Sampled level of the controller-side clock line |
| up_sda_i | input | 1 | Sampled level of the controller-side data line |
| up_scl_pull | output | 1 | Pull-low enable for the controller-side clock line |
| up_sda_pull | output | 1 | Pull-low enable for the controller-side data line |
| dn_scl_i | input | 1 | Sampled level of the target-side clock line |
| dn_sda_i | input | 1 | Sampled level of the target-side data line |
| dn_scl_pull | output | 1 | Pull-low enable for the target-side clock line |
| dn_sda_pull | output | 1 | Pull-low enable for the target-side data line |
| fault | output | 1 | 1 while the two sides are cut apart |

## Verification
The bench sweeps each line in each direction over several low lengths. It checks that the copy appears and clears with a one-cycle lag and that it is never echoed. A design without the release guard would lock both sides low after the first low pulse.

Stuck timing is checked exactly at LIMIT − 1 and LIMIT cycles. Lows split across the two lines, or broken by a single high cycle, must not trip the timer. A shared timer or one that fails to restart would trip too early.

The bench sweeps a stuck data line released after 1 to 20 burst pulses, and a stuck clock line released at cycles that straddle the end of the burst. This sweep checks the burst shape cycle by cycle, the exact cycle of reconnection, and the retry path. A design that samples idle one cycle early or late, or miscounts the pulses, would reconnect on a still-stuck bus or stay isolated one burst too long.

// File: rtl/iso_buf_pkg.sv
`timescale 1ns/1ps
package iso_buf_pkg;
  typedef enum logic [1:0] {
    ST_LINKED = 2'd0,
    ST_BURST  = 2'd1,
    ST_HOLD   = 2'd2
  } iso_state_e;
endpackage

// File: rtl/iso_stuck_timer.sv
`timescale 1ns/1ps
// Counts consecutive low cycles of one line; restarts on any high or when disabled.
module iso_stuck_timer #(
  parameter int unsigned LIMIT = 6000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic line_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire_o = enable_i && !line_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (!enable_i || line_i) cnt <= '0;
    else if (!expire_o)          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/iso_line_mirror.sv
`timescale 1ns/1ps
// Copies an external low from one side to the other, ignoring lows this
// block caused itself (current pull or pull released one cycle ago).
module iso_line_mirror (
  input  logic clk,
  input  logic rst_n,
  input  logic linked_i,
  input  logic a_i,
  input  logic b_i,
  output logic a_pull_o,
  output logic b_pull_o
);
  logic qa, qb, qa_d, qb_d;

  assign a_pull_o = qa && linked_i;
  assign b_pull_o = qb && linked_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qa   <= 1'b0;
      qb   <= 1'b0;
      qa_d <= 1'b0;
      qb_d <= 1'b0;
    end else begin
      qa   <= linked_i && !b_i && !b_pull_o && !qb_d;
      qb   <= linked_i && !a_i && !a_pull_o && !qa_d;
      qa_d <= a_pull_o;
      qb_d <= b_pull_o;
    end
  end
endmodule

// File: rtl/iso_recovery_seq.sv
`timescale 1ns/1ps
// Link / burst / hold sequencing and target-side recovery clock.
module iso_recovery_seq
  import iso_buf_pkg::*;
#(
  parameter int unsigned PULSES = 16,
  parameter int unsigned HALF   = 1000,
  parameter int unsigned LIMIT  = 6000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output iso_state_e state_o,
  output logic       scl_pull_o
);
  localparam int unsigned EDGES = 2 * PULSES;
  localparam int unsigned PH_W  = (HALF > 1)  ? $clog2(HALF)  : 1;
  localparam int unsigned ED_W  = (EDGES > 1) ? $clog2(EDGES) : 1;
  localparam int unsigned HD_W  = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);
  localparam logic [ED_W-1:0] ED_LAST = ED_W'(EDGES - 1);
  localparam logic [HD_W-1:0] HD_LAST = HD_W'(LIMIT - 1);

  iso_state_e      st, st_n;
  logic [PH_W-1:0] ph, ph_n;
  logic [ED_W-1:0] ed, ed_n;
  logic [HD_W-1:0] hd, hd_n;

  always_comb begin
    st_n = st;
    ph_n = ph;
    ed_n = ed;
    hd_n = hd;
    unique case (st)
      ST_LINKED: begin
        if (trip_i) begin
          st_n = ST_BURST;
          ph_n = '0;
          ed_n = '0;
        end
      end
      ST_BURST: begin
        if (ph == PH_LAST) begin
          ph_n = '0;
          if (ed == ED_LAST) begin
            ed_n = '0;
            hd_n = '0;
            st_n = (scl_i && sda_i) ? ST_LINKED : ST_HOLD;
          end else begin
            ed_n = ed + 1'b1;
          end
        end else begin
          ph_n = ph + 1'b1;
        end
      end
      ST_HOLD: begin
        if (hd == HD_LAST) begin
          st_n = ST_BURST;
          hd_n = '0;
          ph_n = '0;
          ed_n = '0;
        end else begin
          hd_n = hd + 1'b1;
        end
      end
      default: st_n = ST_LINKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_LINKED;
      ph <= '0;
      ed <= '0;
      hd <= '0;
    end else begin
      st <= st_n;
      ph <= ph_n;
      ed <= ed_n;
      hd <= hd_n;
    end
  end

  assign state_o    = st;
  assign scl_pull_o = (st == ST_BURST) && !ed[0];
endmodule

// File: rtl/i2c_iso_buffer.sv
`timescale 1ns/1ps
module i2c_iso_buffer
  import iso_buf_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 200000,
  parameter int unsigned STUCK_MS = 30,
  parameter int unsigned REC_KHZ  = 100,
  parameter int unsigned PULSES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_scl_i,
  input  logic up_sda_i,
  output logic up_scl_pull,
  output logic up_sda_pull,
  input  logic dn_scl_i,
  input  logic dn_sda_i,
  output logic dn_scl_pull,
  output logic dn_sda_pull,
  output logic fault
);
  localparam int unsigned LIMIT    = CLK_KHZ * STUCK_MS;
  localparam int unsigned HALF_RAW = CLK_KHZ / (2 * REC_KHZ);
  localparam int unsigned HALF     = (HALF_RAW == 0) ? 1 : HALF_RAW;
  localparam int unsigned LINES    = 2;   // index 0 = clock, 1 = data

  logic [LINES-1:0] up_lv, dn_lv, up_pl, dn_pl, expire;
  iso_state_e       state;
  logic             linked, burst_scl;

  assign up_lv  = {up_sda_i, up_scl_i};
  assign dn_lv  = {dn_sda_i, dn_scl_i};
  assign linked = (state == ST_LINKED);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    iso_stuck_timer #(.LIMIT(LIMIT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (linked),
      .line_i   (dn_lv[i]),
      .expire_o (expire[i])
    );
    iso_line_mirror u_mirror (
      .clk      (clk),
      .rst_n    (rst_n),
      .linked_i (linked),
      .a_i      (up_lv[i]),
      .b_i      (dn_lv[i]),
      .a_pull_o (up_pl[i]),
      .b_pull_o (dn_pl[i])
    );
  end

  iso_recovery_seq #(
    .PULSES (PULSES),
    .HALF   (HALF),
    .LIMIT  (LIMIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_i     (|expire),
    .scl_i      (dn_scl_i),
    .sda_i      (dn_sda_i),
    .state_o    (state),
    .scl_pull_o (burst_scl)
  );

  assign up_scl_pull = up_pl[0];
  assign up_sda_pull = up_pl[1];
  assign dn_scl_pull = dn_pl[0] | burst_scl;
  assign dn_sda_pull = dn_pl[1];
  assign fault       = !linked;
endmodule

module iso_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic up_scl_i,
  input logic up_sda_i,
  input logic up_scl_pull,
  input logic up_sda_pull,
  input logic dn_scl_i,
  input logic dn_sda_i,
  input logic dn_scl_pull,
  input logic dn_sda_pull,
  input logic fault
);
  a_r6_up_released: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!up_scl_pull && !up_sda_pull));

  a_r6_data_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !dn_sda_pull);

  a_r4_no_echo_up_scl: assert property (@(posedge clk) disable iff (!rst_n)
    up_scl_pull |-> !$past(dn_scl_pull));

  a_r4_no_echo_up_sda: assert property (@(posedge clk) disable iff (!rst_n)
    up_sda_pull |-> !$past(dn_sda_pull));

  a_r4_no_echo_dn_sda: assert property (@(posedge clk) disable iff (!rst_n)
    dn_sda_pull |-> !$past(up_sda_pull));

  a_r2_copy_data_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !up_sda_i && !up_sda_pull && !$past(up_sda_pull))
      |=> (dn_sda_pull || fault));

  a_r5_trip_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(!dn_scl_i) || $past(!dn_sda_i)));

  a_r8_idle_at_relink: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> ($past(dn_scl_i) && $past(dn_sda_i)));
endmodule

bind i2c_iso_buffer iso_buffer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .up_scl_i    (up_scl_i),
  .up_sda_i    (up_sda_i),
  .up_scl_pull (up_scl_pull),
  .up_sda_pull (up_sda_pull),
  .dn_scl_i    (dn_scl_i),
  .dn_sda_i    (dn_sda_i),
  .dn_scl_pull (dn_scl_pull),
  .dn_sda_pull (dn_sda_pull),
  .fault       (fault)
);

// File: tb/i2c_iso_buffer_tb.sv
`timescale 1ns/1ps
module i2c_iso_buffer_tb;
  localparam int CLK_KHZ  = 4;
  localparam int STUCK_MS = 10;
  localparam int REC_KHZ  = 1;
  localparam int PULSES   = 16;
  localparam int LIMIT    = CLK_KHZ * STUCK_MS;
  localparam int HALF     = CLK_KHZ / (2 * REC_KHZ);
  localparam int BURST    = 2 * PULSES * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // external drivers: controller (m_*) and targets (s_*)
  logic m_scl = 1'b0, m_sda = 1'b0, s_scl = 1'b0, s_sda_dir = 1'b0;
  logic sda_hold = 1'b0;
  int   rel_n = 0, fall_base = 0, falls = 0;
  logic s_sda;

  logic up_scl_i, up_sda_i, dn_scl_i, dn_sda_i;
  logic up_scl_pull, up_sda_pull, dn_scl_pull, dn_sda_pull, fault;

  assign s_sda    = s_sda_dir | (sda_hold && ((falls - fall_base) < rel_n));
  assign up_scl_i = ~(m_scl | up_scl_pull);
  assign up_sda_i = ~(m_sda | up_sda_pull);
  assign dn_scl_i = ~(s_scl | dn_scl_pull);
  assign dn_sda_i = ~(s_sda | dn_sda_pull);

  i2c_iso_buffer #(
    .CLK_KHZ(CLK_KHZ), .STUCK_MS(STUCK_MS), .REC_KHZ(REC_KHZ), .PULSES(PULSES)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .up_scl_i(up_scl_i), .up_sda_i(up_sda_i),
    .up_scl_pull(up_scl_pull), .up_sda_pull(up_sda_pull),
    .dn_scl_i(dn_scl_i), .dn_sda_i(dn_sda_i),
    .dn_scl_pull(dn_scl_pull), .dn_sda_pull(dn_sda_pull),
    .fault(fault)
  );

  // target model counts falling edges of the target clock line
  logic dn_scl_q = 1'b1;
  always @(posedge clk) begin
    dn_scl_q <= dn_scl_i;
    if (dn_scl_q && !dn_scl_i) falls <= falls + 1;
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pull_of(input bit up_side, input int line);
    if (up_side) return (line == 0) ? up_scl_pull : up_sda_pull;
    return (line == 0) ? dn_scl_pull : dn_sda_pull;
  endfunction

  task automatic drive_src(input bit from_up, input int line, input logic v);
    if (from_up) begin
      if (line == 0) m_scl = v; else m_sda = v;
    end else begin
      if (line == 0) s_scl = v; else s_sda_dir = v;
    end
  endtask

  // R2 / R3 / R4: copy with one-cycle lag, no echo, no latch-up
  task automatic reflect_case(input bit from_up, input int line, input int len);
    logic other, own, expv;
    @(negedge clk);
    drive_src(from_up, line, 1'b1);
    for (int s = 1; s <= len + 2; s++) begin
      @(negedge clk);
      other = pull_of(!from_up, line);
      own   = pull_of(from_up, line);
      expv  = (s <= len);
      check(other == expv, from_up ? "R2 copy down" : "R3 copy up", other, expv);
      check(own == 1'b0, "R4 no echo", own, 0);
      if (s == len) drive_src(from_up, line, 1'b0);
    end
    check(fault == 1'b0, "R5 short low ignored", fault, 0);
  endtask

  // R5..R9: stuck line, burst shape, isolation, reconnect or retry
  task automatic fault_case(input bit on_sda, input int rel);
    int j, p, exp_d;
    bit ok_first;
    logic exp_pull;
    repeat (3) @(negedge clk);
    fall_base = falls;
    if (on_sda) begin
      rel_n = rel;
      sda_hold = 1'b1;
    end else begin
      s_scl = 1'b1;
    end
    repeat (LIMIT - 1) @(negedge clk);
    check(fault == 1'b0, "R5 no trip before limit", fault, 0);
    @(negedge clk);
    check(fault == 1'b1, "R5 trip at limit", fault, 1);
    ok_first = on_sda ? (rel <= PULSES) : (rel <= BURST - 1);
    exp_d    = ok_first ? BURST : 2 * BURST + LIMIT;
    j = 0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    while (fault && j < 1000) begin
      if (j < BURST)              p = j;
      else if (j < BURST + LIMIT) p = -1;
      else                        p = j - BURST - LIMIT;
      exp_pull = (p >= 0) && (((p / HALF) % 2) == 0);
      check(dn_scl_pull == exp_pull, (p < 0) ? "R9 quiet hold" : "R7 burst shape",
            dn_scl_pull, exp_pull);
      check(!up_scl_pull && !up_sda_pull && !dn_sda_pull, "R6 isolation",
            {up_scl_pull, up_sda_pull, dn_sda_pull}, 0);
      if (j == 8) begin
        m_scl = 1'b0;
        m_sda = 1'b0;
      end
      if (!on_sda && j == rel) s_scl = 1'b0;
      j++;
      @(negedge clk);
    end
    check(j == exp_d, ok_first ? "R8 relink after one burst" : "R9 retry burst", j, exp_d);
    check(!up_scl_pull && !up_sda_pull && !dn_scl_pull && !dn_sda_pull && up_scl_i && up_sda_i,
          "R8 idle after relink",
          {up_scl_pull, up_sda_pull, dn_scl_pull, dn_sda_pull, up_scl_i, up_sda_i}, 3);
    sda_hold = 1'b0;
    s_scl    = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({up_scl_pull, up_sda_pull, dn_scl_pull, dn_sda_pull, fault} == 5'b0,
          "R1 reset state", {up_scl_pull, up_sda_pull, dn_scl_pull, dn_sda_pull, fault}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({up_scl_pull, up_sda_pull, dn_scl_pull, dn_sda_pull, fault} == 5'b0,
          "R1 idle after reset", {up_scl_pull, up_sda_pull, dn_scl_pull, dn_sda_pull, fault}, 0);

    for (int d = 0; d < 2; d++)
      for (int ln = 0; ln < 2; ln++)
        for (int len = 1; len <= 4; len++)
          reflect_case(d[0], ln, len);

    // R5: per-line timers and restart on a single high cycle
    @(negedge clk);
    s_scl = 1'b1;
    repeat (LIMIT - 1) @(negedge clk);
    s_scl = 1'b0;
    s_sda_dir = 1'b1;
    repeat (LIMIT - 1) @(negedge clk);
    s_sda_dir = 1'b0;
    check(fault == 1'b0, "R5 separate timers", fault, 0);
    repeat (3) @(negedge clk);
    s_scl = 1'b1;
    repeat (LIMIT - 1) @(negedge clk);
    s_scl = 1'b0;
    @(negedge clk);
    s_scl = 1'b1;
    repeat (LIMIT - 1) @(negedge clk);
    check(fault == 1'b0, "R5 timer restarts", fault, 0);
    s_scl = 1'b0;
    repeat (4) @(negedge clk);

    for (int n = 1; n <= 20; n++) fault_case(1'b1, n);
    fault_case(1'b0, 1);
    fault_case(1'b0, 20);
    fault_case(1'b0, BURST - 1);
    fault_case(1'b0, BURST);
    fault_case(1'b0, BURST + 16);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule